// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous SRAM that keeps its shared data bus fully used under any mix of reads and writes. Commands (address, selects, write enables and a clock-enable) are sampled on the rising clock edge. A read places its word on the output one full cycle after the edge that took its address. A write takes its address at one edge and its data two edges later. Because the read data slot and the write data slot land in the same cycle position relative to the command, reads and writes can alternate on consecutive edges without any idle cycle in between.

The 64-bit word is written as two independently enabled 32-bit halves. Output enable is asynchronous and gates the bus driver at once. The shared bidirectional bus is presented as separate input data, output data and drive-enable ports. A read that hits a write whose data has not yet reached the array returns the newest data, merged per half. Only the low `IDX_W` address bits select a storage word, so simulations can use a small array. The in-flight match compares the full 19-bit address.

Top module: `zt_sram`

## Requirements
- R1: While `rst_n` is low, `dq_oe` is low and every pending command is discarded. After reset is released, no read result is driven until a new read has been issued.
- R2: A read is a selected edge (`sel_n` low, `sel` high) with `clk_en_n` low and `wr_n` high. If `out_en_n` is low and the following edge is not frozen, the addressed word appears on `dq_out` with `dq_oe` high after that following edge.
- R3: A write is a selected edge with `clk_en_n` low and `wr_n` low. Its address is taken at that edge, and its data is taken from `dq_in` at the second unfrozen edge after it. A later read of that address returns the data.
- R4: Reads and writes may be issued on consecutive edges in any order with no idle edge between them. In the output cycle that belongs to a write, `dq_oe` is low.
- R5: Raising `out_en_n` drops `dq_oe` without waiting for a clock edge, and `dq_out` keeps its value. Lowering `out_en_n` again drives the held word.
- R6: `half_wr_n[0]` (active low) enables bits 31:0 and `half_wr_n[1]` enables bits 63:32. A write changes only the halves whose enable was low at its address edge.
- R7: An edge where the device is not selected stores nothing, even if `wr_n` is low. `dq_oe` is low in that edge's output cycle.
- R8: A selected write with both half enables high is an abort. It leaves memory unchanged and its output cycle has `dq_oe` low.
- R9: While `clk_en_n` is high, no command is taken, `dq_in` is not sampled, nothing is written, and `dq_out`/`dq_oe` hold.
- R10: A read issued one edge after a write to the same address returns the write's data for enabled halves and the older content for the others. A read after two such writes returns the newest data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Low: pipeline advances; high: pipeline frozen |
| sel_n | input | 1 | Active-low select |
| sel | input | 1 | Active-high select |
| wr_n | input | 1 | Low: write, high: read |
| half_wr_n | input | 2 | Active-low enables for the two 32-bit halves |
| addr | input | 19 | Word address |
| dq_in | input | 64 | Write data, sampled two edges after its address |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| dq_out | output | 64 | Read data register |
| dq_oe | output | 1 | High when the bus is driven with `dq_out` |

## Verification
Several rules are checked by assertions on every cycle. These are the fixed latency from a read command to a driven result, the released bus in output cycles of writes and deselects, the treatment of write aborts, the shift of commands through the two stages, and the frozen state while clock enable is high. Only the directed scenarios can show the data itself. They cover stored and merged half words, forwarding from writes still waiting for data, ignored data while frozen, the asynchronous release by output enable, and the loss of a read that was cut off by reset.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              sel_ok,
   input  logic              wr_n,
   input  logic [LANES-1:0]  lane_wr_n,
   input  logic [ADDR_W-1:0] addr,
   output op_e               s1_op,
   output logic [ADDR_W-1:0] s1_addr,
   output op_e               s2_op,
   output logic [ADDR_W-1:0] s2_addr,
   output logic [LANES-1:0]  s2_lanes
);
   op_e              new_op;
   logic [LANES-1:0] s1_lanes;

   always_comb begin
      if (!sel_ok)              new_op = OP_IDLE;
      else if (wr_n)            new_op = OP_READ;
      else if (|(~lane_wr_n))   new_op = OP_WRITE;
      else                      new_op = OP_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_op    <= OP_IDLE;
         s1_addr  <= '0;
         s1_lanes <= '0;
         s2_op    <= OP_IDLE;
         s2_addr  <= '0;
         s2_lanes <= '0;
      end else if (adv) begin
         s1_op    <= new_op;
         s1_addr  <= addr;
         s1_lanes <= ~lane_wr_n;
         s2_op    <= s1_op;
         s2_addr  <= s1_addr;
         s2_lanes <= s1_lanes;
      end
   end

   AST_ABORT_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && sel_ok && !wr_n && (&lane_wr_n)) |=> (s1_op != OP_WRITE)); // R8
   AST_STAGE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (s2_op == $past(s1_op))); // R4
   AST_STAGES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> ($stable(s1_op) && $stable(s2_op) && $stable(s2_addr))); // R9
endmodule

// File: rtl/zt_array.sv
module zt_array #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 32,
   parameter int IDX_W  = 6,
   localparam int LANES = DATA_W / LANE_W,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [LANES-1:0]  lane_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rdata
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (we && lane_en[g])
            store[widx] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = store[ridx];
   end
endmodule

// File: rtl/zt_read_port.sv
module zt_read_port
   import zt_sram_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANE_W = 32,
   parameter int ADDR_W = 19,
   localparam int LANES = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  op_e               s1_op,
   input  logic [ADDR_W-1:0] s1_addr,
   input  op_e               s2_op,
   input  logic [ADDR_W-1:0] s2_addr,
   input  logic [LANES-1:0]  s2_lanes,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic              out_en_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_vld,
   output logic              drive
);
   logic              hit;
   logic [DATA_W-1:0] merged;

   assign hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_fwd
      assign merged[g*LANE_W +: LANE_W] = (hit && s2_lanes[g]) ?
         wdata[g*LANE_W +: LANE_W] : arr_rdata[g*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout     <= '0;
         dout_vld <= 1'b0;
      end else if (adv) begin
         dout_vld <= (s1_op == OP_READ);
         if (s1_op == OP_READ)
            dout <= merged;
      end
   end

   assign drive = dout_vld & ~out_en_n;

   AST_OUTPUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> ($stable(dout) && $stable(dout_vld))); // R9
endmodule

// File: rtl/zt_sram.sv
module zt_sram
   import zt_sram_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 19,
   parameter int IDX_W  = 6,
   parameter int LANE_W = 32,
   localparam int LANES = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en_n,
   input  logic              sel_n,
   input  logic              sel,
   input  logic              wr_n,
   input  logic [LANES-1:0]  half_wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   input  logic              out_en_n,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);
   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a multiple of LANE_W");
   end
   if (IDX_W > ADDR_W || IDX_W < 1) begin : g_bad_idx
      $error("IDX_W must lie between 1 and ADDR_W");
   end

   logic              adv, sel_ok, rd_vld;
   op_e               s1_op, s2_op;
   logic [ADDR_W-1:0] s1_addr, s2_addr;
   logic [LANES-1:0]  s2_lanes;
   logic [DATA_W-1:0] arr_rdata;

   assign adv    = ~clk_en_n;
   assign sel_ok = ~sel_n & sel;

   zt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
      .clk(clk), .rst_n(rst_n), .adv(adv), .sel_ok(sel_ok), .wr_n(wr_n),
      .lane_wr_n(half_wr_n), .addr(addr),
      .s1_op(s1_op), .s1_addr(s1_addr),
      .s2_op(s2_op), .s2_addr(s2_addr), .s2_lanes(s2_lanes)
   );

   zt_array #(.DATA_W(DATA_W), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_arr (
      .clk(clk),
      .we(adv && (s2_op == OP_WRITE)),
      .widx(s2_addr[IDX_W-1:0]),
      .lane_en(s2_lanes),
      .wdata(dq_in),
      .ridx(s1_addr[IDX_W-1:0]),
      .rdata(arr_rdata)
   );

   zt_read_port #(.DATA_W(DATA_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .s1_op(s1_op), .s1_addr(s1_addr),
      .s2_op(s2_op), .s2_addr(s2_addr), .s2_lanes(s2_lanes),
      .wdata(dq_in), .arr_rdata(arr_rdata), .out_en_n(out_en_n),
      .dout(dq_out), .dout_vld(rd_vld), .drive(dq_oe)
   );

   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && sel_ok && wr_n) ##1 !clk_en_n |=> rd_vld); // R2
   AST_WRITE_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && sel_ok && !wr_n) ##1 !clk_en_n |=> !rd_vld); // R4
   AST_DESELECT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !sel_ok) ##1 !clk_en_n |=> !rd_vld); // R7
endmodule

// File: tb/zt_sram_test.sv
module zt_sram_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_en_n = 1'b0, sel_n = 1'b1, sel = 1'b0, wr_n = 1'b1;
   logic [1:0]  half_wr_n = 2'b11;
   logic [18:0] addr = '0;
   logic [63:0] dq_in = '0;
   logic        out_en_n = 1'b0;
   logic [63:0] dq_out;
   logic        dq_oe;

   int checks = 0, errors = 0;

   // reference state built from the requirements
   logic [63:0] ref_mem [64];
   bit          known [64];
   bit          p1_rd, p1_wr, p2_wr;
   int          p1_a, p2_a;
   logic [1:0]  p1_en, p2_en;
   logic [63:0] p1_d, p2_d;
   bit          exp_vld, exp_kn;
   logic [63:0] exp_d;

   zt_sram uut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_n(sel_n), .sel(sel),
      .wr_n(wr_n), .half_wr_n(half_wr_n), .addr(addr), .dq_in(dq_in),
      .out_en_n(out_en_n), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   always #5 clk = ~clk;

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model_clear();
      p1_rd = 0; p1_wr = 0; p2_wr = 0; exp_vld = 0;
   endtask

   task automatic check_out(input string tag);
      chk(dq_oe === (exp_vld && !out_en_n), tag, "drive", 64'(dq_oe),
          64'(exp_vld && !out_en_n));
      if (exp_vld && exp_kn)
         chk(dq_out === exp_d, tag, "data", dq_out, exp_d);
   endtask

   // called at a falling edge; ends at the next falling edge after checking
   task automatic step(input logic hold, input logic csn, input logic cs,
                       input logic wn, input logic [1:0] ln, input int a,
                       input logic [63:0] d, input string tag);
      clk_en_n = hold; sel_n = csn; sel = cs; wr_n = wn; half_wr_n = ln;
      addr = 19'(a);
      dq_in = hold ? (64'hDEAD_BEEF_0BAD_F00D ^ 64'(a)) : p2_d;
      @(posedge clk);
      if (!hold) begin
         if (p2_wr) begin
            if (p2_en[0]) ref_mem[p2_a][31:0]  = p2_d[31:0];
            if (p2_en[1]) ref_mem[p2_a][63:32] = p2_d[63:32];
            if (p2_en == 2'b11) known[p2_a] = 1;
         end
         exp_vld = p1_rd;
         if (p1_rd) begin
            exp_d  = ref_mem[p1_a];
            exp_kn = known[p1_a];
         end
         p2_wr = p1_wr; p2_a = p1_a; p2_en = p1_en; p2_d = p1_d;
         p1_rd = !csn && cs && wn;
         p1_wr = !csn && cs && !wn && (ln != 2'b11);
         p1_a = a; p1_en = ~ln; p1_d = d;
      end
      @(negedge clk);
      check_out(tag);
   endtask

   task automatic wr(input int a, input logic [1:0] ln, input logic [63:0] d,
                     input string tag);
      step(0, 0, 1, 0, ln, a, d, tag);
   endtask
   task automatic rd(input int a, input string tag);
      step(0, 0, 1, 1, 2'b11, a, 64'h0, tag);
   endtask
   task automatic nop(input string tag);
      step(0, 1, 0, 1, 2'b11, 0, 64'h0, tag);
   endtask

   function automatic logic [63:0] pat(input int a);
      return {32'hC0DE_0000 | 32'(a), 32'h1234_0000 | 32'(a)};
   endfunction

   task automatic t_reset();
      chk(dq_oe === 1'b0, "R1", "drive after reset", 64'(dq_oe), 64'h0);
      wr(0, 2'b00, 64'h1111_2222_3333_4444, "R1");
      rd(0, "R1");
      rst_n = 1'b0;
      model_clear();
      #1;
      chk(dq_oe === 1'b0, "R1", "drive in reset", 64'(dq_oe), 64'h0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      nop("R1");
      nop("R1");
   endtask

   task automatic t_fill();
      for (int i = 0; i < 8; i++) wr(i, 2'b00, pat(i), "R3");
      for (int i = 0; i < 8; i++) rd(i, "R2");
      nop("R2");
      nop("R2");
   endtask

   task automatic t_mixed();
      wr(10, 2'b00, 64'hAAAA_0000_0000_000A, "R4");
      rd(1, "R4");
      wr(11, 2'b00, 64'hBBBB_0000_0000_000B, "R4");
      rd(10, "R4");
      wr(12, 2'b00, 64'hCCCC_0000_0000_000C, "R4");
      rd(11, "R4");
      rd(12, "R4");
      nop("R4");
      nop("R4");
   endtask

   task automatic t_halves();
      wr(2, 2'b10, 64'hFFFF_FFFF_5555_5555, "R6");
      wr(3, 2'b01, 64'h6666_6666_FFFF_FFFF, "R6");
      nop("R6");
      nop("R6");
      rd(2, "R6");
      rd(3, "R6");
      nop("R6");
      nop("R6");
   endtask

   task automatic t_bypass();
      wr(20, 2'b00, 64'h0A0A_0A0A_A0A0_A0A0, "R10");
      rd(20, "R10");
      wr(20, 2'b01, 64'h7777_8888_FFFF_FFFF, "R10");
      rd(20, "R10");
      wr(21, 2'b00, 64'h2121_2121_2121_2121, "R10");
      nop("R10");
      rd(21, "R10");
      wr(4, 2'b00, 64'h4444_DDDD_4444_DDDD, "R10");
      wr(4, 2'b10, 64'hFFFF_FFFF_EEEE_EEEE, "R10");
      rd(4, "R10");
      nop("R10");
      nop("R10");
   endtask

   task automatic t_deselect();
      step(0, 1, 1, 0, 2'b00, 5, 64'hBAD0_BAD0_BAD0_BAD0, "R7");
      step(0, 0, 0, 0, 2'b00, 5, 64'hBAD1_BAD1_BAD1_BAD1, "R7");
      nop("R7");
      rd(5, "R7");
      nop("R7");
      nop("R7");
   endtask

   task automatic t_abort();
      wr(6, 2'b11, 64'hBAD2_BAD2_BAD2_BAD2, "R8");
      rd(6, "R8");
      nop("R8");
      nop("R8");
   endtask

   task automatic t_freeze();
      rd(1, "R9");
      nop("R9");
      step(1, 0, 1, 1, 2'b11, 2, 64'h0, "R9");
      step(1, 0, 1, 1, 2'b11, 2, 64'h0, "R9");
      wr(7, 2'b00, 64'h7070_7070_0707_0707, "R9");
      step(1, 1, 0, 1, 2'b11, 0, 64'h0, "R9");
      nop("R9");
      step(1, 1, 0, 1, 2'b11, 0, 64'h0, "R9");
      step(1, 1, 0, 1, 2'b11, 0, 64'h0, "R9");
      nop("R9");
      rd(7, "R9");
      nop("R9");
      nop("R9");
   endtask

   task automatic t_oe();
      rd(3, "R5");
      nop("R5");
      out_en_n = 1'b1;
      #1;
      chk(dq_oe === 1'b0, "R5", "drive with oe high", 64'(dq_oe), 64'h0);
      chk(dq_out === exp_d, "R5", "held data", dq_out, exp_d);
      out_en_n = 1'b0;
      #1;
      chk(dq_oe === 1'b1, "R5", "drive restored", 64'(dq_oe), 64'h1);
      nop("R5");
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         known[i] = 0;
         ref_mem[i] = '0;
      end
      p1_a = 0; p2_a = 0; p1_en = 0; p2_en = 0; p1_d = 0; p2_d = 0;
      exp_kn = 0; exp_d = 0;
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill();
      t_mixed();
      t_halves();
      t_bypass();
      t_deselect();
      t_abort();
      t_freeze();
      t_oe();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule